// File: doc/BRIEF.md
# Hardware Page Table Walker

This block refills a translation cache after a miss without software help. When the cache reports a miss on a virtual page number, the walker records that page number, the page-table base and the current address-space identifier. It adds the page number, scaled by the entry size, to the base to get the table-entry address. It then issues one read on a simple request/response memory port.

When the returned entry has its valid bit set, the walker writes the whole entry into the translation cache, tagged with the recorded identifier. In the same cycle it asks the cache to retry the translation that missed. When the valid bit is clear, the walker returns a page-fault code and writes nothing. When the memory flags the read as failed, it returns a separate access-fault code. Each walk adds one memory access ahead of the data access. Only one walk runs at a time, and a busy flag holds off further misses.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `mem_req_valid`, `fill_valid`, `retry` and `fault_valid` are low and `fault_code` is 0.
- R2: `miss_valid` with `busy` low is taken at the clock edge. From the next cycle `busy` is high and `mem_req_valid` is high with `mem_req_addr = ptbr + miss_vpn * PTE_BYTES`, modulo 2^PA_W. The default is 4 bytes per entry.
- R3: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address do not change. The cycle after the handshake, `mem_req_valid` is low.
- R4: `miss_valid` while `busy` is high is ignored. No second read is issued and the walk in progress keeps its page number.
- R5: A response with `mem_rsp_err` low and entry bit 0 set gives a one-cycle pulse on `fill_valid` and `retry` in the following cycle. In that cycle `walk_vpn` is the missed page, `fill_pte` is the full entry, `fill_pfn` is entry bits [29:10] (default widths) and `fault_valid` is low.
- R6: A response with `mem_rsp_err` low and entry bit 0 clear gives a one-cycle `fault_valid` with `fault_code` = 1 (page fault) in the following cycle. `walk_vpn` holds the page, and there is no fill and no retry.
- R7: A response with `mem_rsp_err` high gives `fault_valid` with `fault_code` = 2 (access fault), whatever the entry holds. There is no fill.
- R8: The base and the identifier are sampled when the miss is taken. Changes to `ptbr` or `cur_asid` during the walk change neither the read address nor `fill_asid`.
- R9: The cycle after a fill or fault pulse, `busy` is low and a new miss is taken.
- R10: `mem_rsp_valid` while no read is outstanding is ignored. It causes no fill, no fault and no change of `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Translation miss to be refilled |
| miss_vpn | input | VA_W-OFFSET_W | Virtual page number that missed |
| busy | output | 1 | A walk is in progress; misses are not taken |
| ptbr | input | PA_W | Physical base address of the page table |
| cur_asid | input | ASID_W | Address-space identifier of the running context |
| mem_req_valid | output | 1 | Table-entry read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | PA_W | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_err | input | 1 | Read failed |
| mem_rsp_data | input | 8*PTE_BYTES | Table entry read |
| fill_valid | output | 1 | Write the entry into the translation cache |
| walk_vpn | output | VA_W-OFFSET_W | Page number of the finishing walk |
| fill_asid | output | ASID_W | Identifier tag for the fill |
| fill_pte | output | 8*PTE_BYTES | Full entry to install |
| fill_pfn | output | PFN_W | Frame number field of the entry |
| retry | output | 1 | Cache should replay the missed translation |
| fault_valid | output | 1 | Walk ended in a fault |
| fault_code | output | 2 | 1 page fault, 2 access fault, 0 otherwise |

## Verification
The bench stalls the request handshake while also raising a second miss. A walker that lets its address drift, or that starts a second walk, shows up as a changed address or an extra read. It changes the base and identifier right after a miss is taken. A design that reads them live would issue the read to the wrong entry or tag the fill with the new context. The bench pairs a failed read with an entry whose valid bit is set, and a faulting design would then install garbage in place of the access fault. It also wraps the address at the top of the physical space and sends responses while idle, which would catch a walker that takes stray data.

// File: rtl/ptw_pkg.sv
// Package: shared types for the page table walker.
// Holds the sequencer state encoding and the fault codes seen at the top ports.
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_FILL  = 3'd3,
        ST_FAULT = 3'd4
    } walk_state_e;

    localparam logic [1:0] FLT_NONE   = 2'd0;
    localparam logic [1:0] FLT_PAGE   = 2'd1;
    localparam logic [1:0] FLT_ACCESS = 2'd2;

endpackage

// File: rtl/ptw_addr_gen.sv
// Module: ptw_addr_gen
// Forms the byte address of a table entry as base + vpn * entry size.
// Assumes the result wraps modulo 2^PA_W. A power-of-two entry size uses a
// shift; any other size uses a multiplier.
module ptw_addr_gen #(
    parameter int PA_W      = 32,
    parameter int VPN_W     = 20,
    parameter int PTE_BYTES = 4
) (
    input  logic [PA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    output logic [PA_W-1:0]  pte_addr
);
    localparam bit IS_POW2 = ((PTE_BYTES & (PTE_BYTES - 1)) == 0);
    localparam int SHIFT   = $clog2(PTE_BYTES);

    logic [PA_W-1:0] vpn_ext;
    logic [PA_W-1:0] scaled;

    // Zero-extend or truncate the page number to the address width.
    always_comb vpn_ext = PA_W'(vpn);

    generate
        if (IS_POW2) begin : g_shift
            // Entry size is a power of two: scale with a shift.
            always_comb scaled = vpn_ext << SHIFT;
        end else begin : g_mult
            // Entry size is not a power of two: scale with a multiplier.
            always_comb scaled = PA_W'(vpn_ext * PA_W'(PTE_BYTES));
        end
    endgenerate

    // Add the scaled index to the table base.
    always_comb pte_addr = base + scaled;

endmodule

// File: rtl/ptw_ctx.sv
// Module: ptw_ctx
// Holds the context of the walk in progress: page number, table base and
// identifier, all sampled when a miss is taken, plus the entry from the
// memory response. Assumes the sequencer raises take_miss only from idle and
// take_rsp only while a read is outstanding.
module ptw_ctx #(
    parameter int PA_W   = 32,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PTE_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_miss,
    input  logic              take_rsp,
    input  logic [VPN_W-1:0]  in_vpn,
    input  logic [PA_W-1:0]   in_base,
    input  logic [ASID_W-1:0] in_asid,
    input  logic [PTE_W-1:0]  in_pte,
    output logic [VPN_W-1:0]  ctx_vpn,
    output logic [PA_W-1:0]   ctx_base,
    output logic [ASID_W-1:0] ctx_asid,
    output logic [PTE_W-1:0]  ctx_pte
);
    // Sample the miss context once, at the start of the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_vpn  <= '0;
            ctx_base <= '0;
            ctx_asid <= '0;
        end else if (take_miss) begin
            ctx_vpn  <= in_vpn;
            ctx_base <= in_base;
            ctx_asid <= in_asid;
        end
    end

    // Keep the returned table entry for the fill cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_pte <= '0;
        end else if (take_rsp) begin
            ctx_pte <= in_pte;
        end
    end

    // R8: the sampled identifier moves only when a new miss is taken.
    assert_asid_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !take_miss |=> ctx_asid == $past(ctx_asid));

endmodule

// File: rtl/ptw_fsm.sv
// Module: ptw_fsm
// Sequencer for one walk: idle, issue read, wait for data, then fill or
// fault for one cycle, then back to idle. Assumes the memory answers once
// per accepted request. Responses seen in any state other than wait are
// dropped.
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       miss_valid,
    input  logic       mem_req_ready,
    input  logic       mem_rsp_valid,
    input  logic       mem_rsp_err,
    input  logic       pte_valid,
    output logic       take_miss,
    output logic       take_rsp,
    output logic       busy,
    output logic       mem_req_valid,
    output logic       fill_valid,
    output logic       retry,
    output logic       fault_valid,
    output logic [1:0] fault_code
);
    walk_state_e state_q, state_d;
    logic [1:0]  code_q, code_d;

    // Next-state and fault-code selection.
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            ST_IDLE:  if (miss_valid) state_d = ST_ISSUE;
            ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        state_d = ST_FAULT;
                        code_d  = FLT_ACCESS;
                    end else if (!pte_valid) begin
                        state_d = ST_FAULT;
                        code_d  = FLT_PAGE;
                    end else begin
                        state_d = ST_FILL;
                        code_d  = FLT_NONE;
                    end
                end
            end
            ST_FILL:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State and fault-code registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= FLT_NONE;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    // Decode the outputs from the current state.
    always_comb begin
        take_miss     = (state_q == ST_IDLE) && miss_valid;
        take_rsp      = (state_q == ST_WAIT) && mem_rsp_valid;
        busy          = (state_q != ST_IDLE);
        mem_req_valid = (state_q == ST_ISSUE);
        fill_valid    = (state_q == ST_FILL);
        retry         = (state_q == ST_FILL);
        fault_valid   = (state_q == ST_FAULT);
        fault_code    = (state_q == ST_FAULT) ? code_q : FLT_NONE;
    end

    // R2: a walk starts only on a miss.
    assert_start_on_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(miss_valid));
    // R3: an unaccepted request stays up.
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid);
    // R5: a fill follows a clean response holding a valid entry.
    assert_fill_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> $past(mem_rsp_valid && !mem_rsp_err && pte_valid));
    // R6: a page fault follows a clean response holding an invalid entry.
    assert_page_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && fault_code == FLT_PAGE) |-> $past(mem_rsp_valid && !mem_rsp_err && !pte_valid));
    // R7: an access fault follows a failed read.
    assert_access_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && fault_code == FLT_ACCESS) |-> $past(mem_rsp_valid && mem_rsp_err));
    // R9: the walker is free again after finishing.
    assert_back_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid || fault_valid) |=> !busy);

endmodule

// File: rtl/ptw_walker.sv
// Module: ptw_walker (top)
// Single-level hardware page table walker. On a translation miss it reads
// one table entry at base + vpn * PTE_BYTES. A valid entry is installed
// with retry; an invalid entry or a failed read is reported as a fault.
// Assumes entry bit 0 is the valid flag and the frame number sits at
// PFN_LSB. One walk is in flight at a time.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int OFFSET_W  = 12,
    parameter int PA_W      = 32,
    parameter int PTE_BYTES = 4,
    parameter int ASID_W    = 8,
    parameter int PFN_LSB   = 10,
    parameter int PFN_W     = 20,
    localparam int VPN_W    = VA_W - OFFSET_W,
    localparam int PTE_W    = 8 * PTE_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [VPN_W-1:0]  miss_vpn,
    output logic              busy,
    input  logic [PA_W-1:0]   ptbr,
    input  logic [ASID_W-1:0] cur_asid,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              fill_valid,
    output logic [VPN_W-1:0]  walk_vpn,
    output logic [ASID_W-1:0] fill_asid,
    output logic [PTE_W-1:0]  fill_pte,
    output logic [PFN_W-1:0]  fill_pfn,
    output logic              retry,
    output logic              fault_valid,
    output logic [1:0]        fault_code
);
    localparam int PTE_VALID_BIT = 0;

    logic              take_miss, take_rsp;
    logic [VPN_W-1:0]  ctx_vpn;
    logic [PA_W-1:0]   ctx_base;
    logic [ASID_W-1:0] ctx_asid;
    logic [PTE_W-1:0]  ctx_pte;

    ptw_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_valid    (miss_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_err   (mem_rsp_err),
        .pte_valid     (mem_rsp_data[PTE_VALID_BIT]),
        .take_miss     (take_miss),
        .take_rsp      (take_rsp),
        .busy          (busy),
        .mem_req_valid (mem_req_valid),
        .fill_valid    (fill_valid),
        .retry         (retry),
        .fault_valid   (fault_valid),
        .fault_code    (fault_code)
    );

    ptw_ctx #(
        .PA_W   (PA_W),
        .VPN_W  (VPN_W),
        .ASID_W (ASID_W),
        .PTE_W  (PTE_W)
    ) u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_miss (take_miss),
        .take_rsp  (take_rsp),
        .in_vpn    (miss_vpn),
        .in_base   (ptbr),
        .in_asid   (cur_asid),
        .in_pte    (mem_rsp_data),
        .ctx_vpn   (ctx_vpn),
        .ctx_base  (ctx_base),
        .ctx_asid  (ctx_asid),
        .ctx_pte   (ctx_pte)
    );

    ptw_addr_gen #(
        .PA_W      (PA_W),
        .VPN_W     (VPN_W),
        .PTE_BYTES (PTE_BYTES)
    ) u_addr (
        .base     (ctx_base),
        .vpn      (ctx_vpn),
        .pte_addr (mem_req_addr)
    );

    // Present the sampled context and entry fields to the cache.
    always_comb begin
        walk_vpn  = ctx_vpn;
        fill_asid = ctx_asid;
        fill_pte  = ctx_pte;
        fill_pfn  = ctx_pte[PFN_LSB +: PFN_W];
    end

    // R3: the read address is held until the memory takes it.
    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr));
    // R5: fill and fault never share a cycle.
    assert_fill_xor_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_valid && fault_valid));

endmodule

// File: tb/ptw_walker_tb.sv
// Scoreboard bench: the walk task pushes expected outcomes, a monitor pops
// and compares them when the walker reports a fill or a fault.
module ptw_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [19:0] miss_vpn = '0;
    logic        busy;
    logic [31:0] ptbr = '0;
    logic [7:0]  cur_asid = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_err = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        fill_valid;
    logic [19:0] walk_vpn;
    logic [7:0]  fill_asid;
    logic [31:0] fill_pte;
    logic [19:0] fill_pfn;
    logic        retry;
    logic        fault_valid;
    logic [1:0]  fault_code;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit          is_fault;
        logic [1:0]  code;
        logic [19:0] vpn;
        logic [7:0]  asid;
        logic [31:0] pte;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    ptw_walker u_dut (
        .clk (clk), .rst_n (rst_n), .miss_valid (miss_valid), .miss_vpn (miss_vpn),
        .busy (busy), .ptbr (ptbr), .cur_asid (cur_asid),
        .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
        .mem_req_addr (mem_req_addr), .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_err (mem_rsp_err), .mem_rsp_data (mem_rsp_data),
        .fill_valid (fill_valid), .walk_vpn (walk_vpn), .fill_asid (fill_asid),
        .fill_pte (fill_pte), .fill_pfn (fill_pfn), .retry (retry),
        .fault_valid (fault_valid), .fault_code (fault_code)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Monitor: compare each reported outcome with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && (fill_valid || fault_valid)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected outcome", {62'd0, fill_valid, fault_valid}, 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.is_fault) begin
                    chk(fault_valid && !fill_valid && !retry, "R6 R7 fault without fill",
                        {61'd0, fault_valid, fill_valid, retry}, 64'd4);
                    chk(fault_code == e.code, "R6 R7 fault code", fault_code, e.code);
                    chk(walk_vpn == e.vpn, "R6 fault vpn", walk_vpn, e.vpn);
                end else begin
                    chk(fill_valid && retry && !fault_valid, "R5 fill with retry",
                        {61'd0, fill_valid, retry, fault_valid}, 64'd6);
                    chk(walk_vpn == e.vpn, "R5 fill vpn", walk_vpn, e.vpn);
                    chk(fill_pte == e.pte, "R5 fill pte", fill_pte, e.pte);
                    chk(fill_pfn == e.pte[29:10], "R5 fill pfn", fill_pfn, e.pte[29:10]);
                    chk(fill_asid == e.asid, "R8 fill asid", fill_asid, e.asid);
                end
            end
        end
    end

    // Driver: one complete walk with a stalled handshake and response latency.
    task automatic walk(input logic [19:0] vpn, input logic [7:0] asid, input logic [31:0] base,
                        input logic [31:0] pte, input bit err, input int stall, input int lat);
        logic [31:0] exp_addr;
        exp_t e;
        exp_addr = base + {10'd0, vpn, 2'b00};
        @(negedge clk);
        ptbr = base; cur_asid = asid; miss_valid = 1'b1; miss_vpn = vpn;
        @(negedge clk);
        miss_valid = 1'b0; ptbr = ~base; cur_asid = ~asid;
        chk(busy, "R2 busy after miss", busy, 1);
        chk(mem_req_valid, "R2 read issued", mem_req_valid, 1);
        chk(mem_req_addr == exp_addr, "R2 R8 entry address", mem_req_addr, exp_addr);
        for (int i = 0; i < stall; i++) begin
            miss_valid = (i == 0);
            miss_vpn = vpn ^ 20'h5;
            @(negedge clk);
            miss_valid = 1'b0;
            chk(mem_req_valid, "R3 request held", mem_req_valid, 1);
            chk(mem_req_addr == exp_addr, "R3 R4 address held", mem_req_addr, exp_addr);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(!mem_req_valid, "R3 request dropped after handshake", mem_req_valid, 0);
        repeat (lat) @(negedge clk);
        e.is_fault = err || !pte[0];
        e.code = err ? 2'd2 : (!pte[0] ? 2'd1 : 2'd0);
        e.vpn = vpn; e.asid = asid; e.pte = pte;
        exp_q.push_back(e);
        mem_rsp_valid = 1'b1; mem_rsp_data = pte; mem_rsp_err = err;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = 32'hDEAD_BEEF;
        @(negedge clk);
        chk(!busy, "R9 idle after walk", busy, 0);
        chk(!mem_req_valid, "R4 no second read", mem_req_valid, 0);
        chk(exp_q.size() == 0, "R5 R6 R7 outcome reported", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req_valid && !fill_valid && !fault_valid && !retry && fault_code == 0,
            "R1 outputs in reset", {58'd0, busy, mem_req_valid, fill_valid, fault_valid, retry, 1'b0}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req_valid && !fill_valid && !fault_valid, "R1 outputs after reset",
            {60'd0, busy, mem_req_valid, fill_valid, fault_valid}, 0);
        // R10: stray responses while idle.
        mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0000_0401;
        repeat (2) @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk(!busy && !fill_valid && !fault_valid, "R10 idle response ignored",
            {61'd0, busy, fill_valid, fault_valid}, 0);
        @(negedge clk);
        chk(!fill_valid && !fault_valid, "R10 no late outcome", {62'd0, fill_valid, fault_valid}, 0);
        walk(20'h00012, 8'h3C, 32'h8000_0000, 32'h1234_5C01, 1'b0, 0, 0);
        walk(20'hABCDE, 8'h05, 32'h4000_1000, 32'h3FFF_FC07, 1'b0, 3, 2);
        walk(20'h00777, 8'h11, 32'h0010_0000, 32'h0ABC_D400, 1'b0, 1, 1);
        walk(20'h00042, 8'h22, 32'h0020_0000, 32'h0000_0C01, 1'b1, 2, 0);
        walk(20'h00043, 8'h23, 32'h0020_0000, 32'h0000_0000, 1'b1, 0, 3);
        walk(20'h00400, 8'hFF, 32'hFFFF_F000, 32'h0000_4001, 1'b0, 0, 0);
        walk(20'hFFFFF, 8'h00, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 2, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule